// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel TFT panel, together with the current pixel and line positions, which a downstream pixel pipeline uses to fetch and place data. Each output is driven for one pixel-clock cycle at a time. The timing is fully programmable through a simple write port. Eight word registers hold the polarity and edge options, the two sync widths, the line and frame totals, and the horizontal and vertical active windows. Window limits are absolute counter positions measured from the leading edge of sync.

Software writes the geometry and then sets the enable bit. A running frame is never cut short. A disable request is held until the last pixel of the frame, and the block then raises a stopped flag that software polls. Geometry writes go into a pending copy that is adopted only at a frame boundary. This lets software reprogram the timing while the panel is being driven.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, hsync, vsync, de, pclk_fall, running and disabled are all 0, and h_pos and v_pos are 0.
- R2: The write port decodes word addresses as follows: 0 = options, 1 = horizontal sync width in bits 9:0, 2 = vertical sync width in bits 9:0, 3 = line total in bits 31:16 and frame total in lines in bits 15:0, 4 = horizontal window start in bits 31:16 and end in bits 15:0, 5 = vertical window with the same layout, 6 = control, 7 = status. While running, h_pos counts 0 to line total minus 1. v_pos advances when h_pos wraps and returns to 0 after frame total minus 1, so a frame lasts line total times frame total cycles.
- R3: Horizontal sync is active while h_pos is below the horizontal sync width. Vertical sync is active while v_pos is below the vertical sync width.
- R4: de is active while h_pos is at least the horizontal start and below the horizontal end, and v_pos is at least the vertical start and below the vertical end.
- R5: Options bit 0 makes hsync active low, bit 1 makes vsync active low, and bit 2 makes de active low. Bit 3 drives the pclk_fall output, which selects launch on the falling pixel-clock edge.
- R6: Writing control with bit 0 set and bit 1 clear while idle sets running on the next cycle, with h_pos and v_pos both at 0.
- R7: Writing control with bit 1 set while running lets the current frame finish. On the cycle after the last pixel, running drops and disabled rises, and the sync and de outputs sit at their inactive levels.
- R8: Writing status with bit 0 clear clears disabled. An enable write is ignored while disabled is set.
- R9: Geometry and option writes take effect only at the start of a frame, meaning the enable cycle or the cycle after a frame's last pixel.
- R10: A disable write while idle sets disabled on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register word address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| de | output | 1 | Data enable, programmable polarity |
| pclk_fall | output | 1 | Falling-edge pixel launch select |
| running | output | 1 | Generator is producing frames |
| disabled | output | 1 | Stopped flag after a disable request |
| h_pos | output | CW (16) | Pixel position within the line |
| v_pos | output | CW (16) | Line position within the frame |

## Verification
The in-line properties check the following on every cycle:
- the pixel counter steps by one and stays below the line total;
- the line counter moves only when the pixel counter wraps;
- running falls only after a frame's last pixel;
- the pending copy is adopted only at a frame boundary;
- running and the stopped flag are never both set.

The actual strobe widths, window placement and polarity inversions can only be shown by the bench. It counts active cycles over whole frames for several geometries. It also covers the ordering scenarios: a disable request mid-frame, an enable refused before the stopped flag is cleared, and a sync width rewritten while a frame is in flight.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int CW = 16,
  parameter int SW = 10,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclk_fall,
  output logic          running,
  output logic          disabled,
  output logic [CW-1:0] h_pos,
  output logic [CW-1:0] v_pos
);
  localparam logic [AW-1:0] A_OPT  = AW'(0);
  localparam logic [AW-1:0] A_HSW  = AW'(1);
  localparam logic [AW-1:0] A_VSW  = AW'(2);
  localparam logic [AW-1:0] A_TOT  = AW'(3);
  localparam logic [AW-1:0] A_HWIN = AW'(4);
  localparam logic [AW-1:0] A_VWIN = AW'(5);
  localparam logic [AW-1:0] A_CTRL = AW'(6);
  localparam logic [AW-1:0] A_STAT = AW'(7);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [3:0]    p_opt, a_opt;
  logic [CW-1:0] p_hsw, p_vsw, p_ht, p_vt, p_hds, p_hde, p_vds, p_vde;
  logic [CW-1:0] a_hsw, a_vsw, a_ht, a_vt, a_hds, a_hde, a_vds, a_vde;
  logic [CW-1:0] hc, vc;
  logic          run, req, done;

  wire ctrl_wr = wr_en && (wr_addr == A_CTRL);
  wire stop    = ctrl_wr && wr_data[1];
  wire go      = ctrl_wr && wr_data[0] && !wr_data[1] && !run && !done;
  wire h_last  = (hc == a_ht - ONE);
  wire last_px = h_last && (vc == a_vt - ONE);
  wire load    = go || (run && last_px);
  wire halt    = run && last_px && (req || stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_opt <= '0; p_hsw <= '0; p_vsw <= '0; p_ht <= '0; p_vt <= '0;
      p_hds <= '0; p_hde <= '0; p_vds <= '0; p_vde <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_OPT:  p_opt <= wr_data[3:0];
        A_HSW:  p_hsw <= CW'(wr_data[SW-1:0]);
        A_VSW:  p_vsw <= CW'(wr_data[SW-1:0]);
        A_TOT:  begin p_ht  <= wr_data[16 +: CW]; p_vt  <= wr_data[0 +: CW]; end
        A_HWIN: begin p_hds <= wr_data[16 +: CW]; p_hde <= wr_data[0 +: CW]; end
        A_VWIN: begin p_vds <= wr_data[16 +: CW]; p_vde <= wr_data[0 +: CW]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_opt <= '0; a_hsw <= '0; a_vsw <= '0; a_ht <= '0; a_vt <= '0;
      a_hds <= '0; a_hde <= '0; a_vds <= '0; a_vde <= '0;
    end else if (load) begin
      a_opt <= p_opt; a_hsw <= p_hsw; a_vsw <= p_vsw; a_ht <= p_ht; a_vt <= p_vt;
      a_hds <= p_hds; a_hde <= p_hde; a_vds <= p_vds; a_vde <= p_vde;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0; vc <= '0;
    end else if (go) begin
      hc <= '0; vc <= '0;
    end else if (run) begin
      if (h_last) begin
        hc <= '0;
        vc <= last_px ? '0 : vc + ONE;
      end else begin
        hc <= hc + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; req <= 1'b0; done <= 1'b0;
    end else begin
      if (go) run <= 1'b1;
      else if (halt) run <= 1'b0;

      if (!run || last_px) req <= 1'b0;
      else if (stop) req <= 1'b1;

      if (halt || (!run && stop)) done <= 1'b1;
      else if (wr_en && wr_addr == A_STAT && !wr_data[0]) done <= 1'b0;
    end
  end

  wire hs_on = run && (hc < a_hsw);
  wire vs_on = run && (vc < a_vsw);
  wire de_on = run && (hc >= a_hds) && (hc < a_hde) && (vc >= a_vds) && (vc < a_vde);

  assign hsync     = hs_on ^ a_opt[0];
  assign vsync     = vs_on ^ a_opt[1];
  assign de        = de_on ^ a_opt[2];
  assign pclk_fall = a_opt[3];
  assign running   = run;
  assign disabled  = done;
  assign h_pos     = hc;
  assign v_pos     = vc;

  AST_HC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && hc != '0) |-> hc == $past(hc) + ONE); // R2
  AST_VC_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && vc != $past(vc)) |-> $past(hc) == $past(a_ht) - ONE); // R2
  AST_H_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && a_ht != '0) |-> hc < a_ht); // R2
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(last_px) && done)); // R7
  AST_NO_RUN_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !run); // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !(hc == '0 && vc == '0)) |->
      ($stable(a_ht) && $stable(a_vt) && $stable(a_hsw) && $stable(a_opt) && $stable(a_hde))); // R9
endmodule

// File: tb/test_lcd_timing_gen.sv
`timescale 1ns/1ps
module test_lcd_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, de, pclk_fall, running, disabled;
  logic [15:0] h_pos, v_pos;

  always #2.5 clk = ~clk;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk_fall(pclk_fall),
    .running(running), .disabled(disabled), .h_pos(h_pos), .v_pos(v_pos));

  // cfg, hsw, vsw, ht, vt, hds, hde, vds, vde, exp_hs, exp_vs, exp_de
  localparam int NV = 3;
  localparam int VEC [NV][12] = '{
    '{ 0, 2, 1, 10, 6, 3,  8, 2, 5, 12, 10, 15},
    '{15, 1, 2,  8, 5, 2,  7, 3, 4,  5, 16,  5},
    '{ 5, 3, 1, 12, 4, 4, 12, 1, 4, 12, 12, 24}
  };

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({hsync, vsync, de, pclk_fall} == 4'b0, "R1", {hsync, vsync, de, pclk_fall}, 0);
    chk(running == 0 && disabled == 0, "R1", {running, disabled}, 0);
    chk(h_pos == 0 && v_pos == 0, "R1", h_pos + v_pos, 0);

    // R10 disable while idle
    wr(6, 32'h2);
    chk(disabled == 1, "R10", disabled, 1);
    wr(7, 32'h0);
    chk(disabled == 0, "R8", disabled, 0);

    for (int k = 0; k < NV; k++) begin
      int ht, vt, n, hs, vs, dc, perr, cfg;
      cfg = VEC[k][0]; ht = VEC[k][3]; vt = VEC[k][4]; n = ht * vt;
      wr(0, cfg);
      wr(1, VEC[k][1]);
      wr(2, VEC[k][2]);
      wr(3, (ht << 16) | vt);
      wr(4, (VEC[k][5] << 16) | VEC[k][6]);
      wr(5, (VEC[k][7] << 16) | VEC[k][8]);
      wr(6, 32'h1);
      // R6 start at origin
      chk(running == 1 && h_pos == 0 && v_pos == 0, "R6", h_pos + v_pos + 16'(!running), 0);
      chk(pclk_fall == cfg[3], "R5", pclk_fall, cfg[3]);
      hs = 0; vs = 0; dc = 0; perr = 0;
      for (int i = 0; i < n; i++) begin
        if (hsync != cfg[0]) hs++;
        if (vsync != cfg[1]) vs++;
        if (de != cfg[2]) dc++;
        if (h_pos != 16'(i % ht) || v_pos != 16'(i / ht)) perr++;
        @(negedge clk);
      end
      chk(perr == 0, "R2", perr, 0);
      chk(h_pos == 0 && v_pos == 0, "R2", h_pos + v_pos, 0);
      chk(hs == VEC[k][9], "R3 hsync", hs, VEC[k][9]);
      chk(vs == VEC[k][10], "R3 vsync", vs, VEC[k][10]);
      chk(dc == VEC[k][11], "R4", dc, VEC[k][11]);
      // R7 disable completes at frame end
      wr(6, 32'h2);
      repeat (n - 2) @(negedge clk);
      chk(running == 1 && disabled == 0 && h_pos == 16'(ht - 1) && v_pos == 16'(vt - 1),
          "R7 pending", h_pos, ht - 1);
      @(negedge clk);
      chk(running == 0 && disabled == 1, "R7 stopped", {running, disabled}, 1);
      chk({hsync, vsync, de} == {cfg[2], cfg[1], cfg[0]} || {de, vsync, hsync} == cfg[2:0],
          "R5 idle levels", {de, vsync, hsync}, cfg & 7);
      if (k == 0) begin
        wr(6, 32'h1);
        chk(running == 0, "R8 enable refused", running, 0);
      end
      wr(7, 32'h0);
      chk(disabled == 0, "R8 clear", disabled, 0);
    end

    // R9 shadowed geometry
    begin
      int ht, n;
      ht = VEC[0][3]; n = ht * VEC[0][4];
      wr(0, VEC[0][0]);
      wr(1, VEC[0][1]);
      wr(2, VEC[0][2]);
      wr(3, (ht << 16) | VEC[0][4]);
      wr(4, (VEC[0][5] << 16) | VEC[0][6]);
      wr(5, (VEC[0][7] << 16) | VEC[0][8]);
      wr(6, 32'h1);
      wr(1, 32'd4);
      repeat (ht + 1) @(negedge clk);
      chk(h_pos == 2 && hsync == 0, "R9 old width kept", hsync, 0);
      repeat (n - ht) @(negedge clk);
      chk(h_pos == 2 && v_pos == 0 && hsync == 1, "R9 new width applied", hsync, 1);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule